// File: doc/BRIEF.md
# Line Codec with DPLL Clock Recovery

This block is the line-side coder of one serial channel. On the transmit side it takes a plain bit stream, one bit per cycle of a bit strobe, and drives the line in one of three encodings: NRZ, NRZI or FM (bi-phase space). On the receive side it synchronizes the incoming line and follows its edges with a digital phase-locked loop built from a bit-phase counter. At the middle of each recovered cell it delivers one decoded bit with a one-cycle valid strobe.

The core clock is the oversampling clock. A cell lasts `OSR_FM` clocks in FM and `OSR_NRZ` clocks in NRZ and NRZI. Those are 16 and 32 by default, which gives top rates of clock/16 and clock/32. The loop runs in one of two states. In hunt, the first edge seen is taken as a cell boundary and the counter snaps to it. Once tracking, an edge that falls outside the boundary window moves the counter one count earlier or later.

In FM, two cells in a row with no boundary edge raise a clock-missing flag and put the loop back into hunt. A bypass select stops the loop from being used. Instead, the line is sampled on each rising edge of an external bit clock, which can run up to a quarter of the core clock.

Top module: `line_codec`

## Requirements
- R1: With mode 2'b00 (NRZ, code 2'b11 behaves the same), on the clock edge that sees `tx_stb` high, `tx_line` takes the value of `tx_bit`. Without a strobe it holds.
- R2: With mode 2'b01 (NRZI), a strobed 0 inverts `tx_line` and a strobed 1 leaves it unchanged.
- R3: With mode 2'b10 (FM), every strobed bit inverts `tx_line` at the strobe edge. A strobed 0 inverts it a second time `OSR_FM/2` clocks later; a strobed 1 does not.
- R4: In NRZ with the loop in use, a stream with one strobe every `OSR_NRZ` clocks, looped from `tx_line` to `rx_line`, is reproduced bit for bit on `rx_bit`/`rx_vld`, once a leading edge has been seen.
- R5: In NRZI the receiver outputs 1 when the centre sample equals the previous centre sample and 0 otherwise, so a looped NRZI stream is reproduced bit for bit.
- R6: In FM, with cells of `OSR_FM` clocks, the receiver compares the line at one quarter and at three quarters of the cell and outputs 1 when they are equal. A looped FM stream is reproduced bit for bit.
- R7: `clk_miss` is raised only in FM with the loop in use, after two consecutive cells with no boundary edge. The next line edge clears it and realigns the counter. In any other mode it reads 0 one clock later.
- R8: After reset `tx_line` is 1, `rx_vld` is 0 and `clk_miss` is 0.
- R9: With `ext_sel` high, each rising edge of `ext_bclk`, after synchronization, samples the line and emits one bit: NRZ when mode is not 2'b01 and NRZI when it is. This holds for bit clocks of up to a quarter of the core clock.
- R10: An edge after the expected boundary holds the counter for one clock, and an edge before it advances the counter by two. As a result, an NRZ line whose cells are one clock longer or shorter than `OSR_NRZ` still yields exactly one correct bit per cell.
- R11: `rx_vld` is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling core clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 2 | Line encoding: 00 NRZ, 01 NRZI, 10 FM, 11 NRZ |
| ext_sel | input | 1 | Use the external bit clock instead of the loop |
| ext_bclk | input | 1 | External receive bit clock (asynchronous) |
| tx_bit | input | 1 | Bit to transmit |
| tx_stb | input | 1 | One-clock strobe that starts a transmit cell |
| tx_line | output | 1 | Encoded transmit line |
| rx_line | input | 1 | Received line (asynchronous) |
| rx_bit | output | 1 | Decoded receive bit |
| rx_vld | output | 1 | One-clock strobe marking `rx_bit` valid |
| clk_miss | output | 1 | FM boundary edges missing for two cells |

## Verification
The bench builds the codec with `OSR_FM = 8` and `OSR_NRZ = 16`, which halves every cell. With cells that short, every encoding can be swept over many computed payloads in loopback, together with external-clock runs and two off-rate lines. The FM quarter, half and three-quarter points (2, 4 and 6) remain distinct counter values, so the boundary, mid-cell and early windows are still separate. A one-clock rate error is about 6 % of an NRZ cell, which is large enough that a loop without correction would drop or repeat bits within a few dozen cells.

// File: rtl/line_codec.sv
module line_codec #(
  parameter int OSR_FM  = 16,
  parameter int OSR_NRZ = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       ext_sel,
  input  logic       ext_bclk,
  input  logic       tx_bit,
  input  logic       tx_stb,
  output logic       tx_line,
  input  logic       rx_line,
  output logic       rx_bit,
  output logic       rx_vld,
  output logic       clk_miss
);
  localparam int OSR_MAX = (OSR_NRZ > OSR_FM) ? OSR_NRZ : OSR_FM;
  localparam int CW = $clog2(OSR_MAX);
  localparam logic [CW-1:0] FM_Q  = CW'(OSR_FM / 4);
  localparam logic [CW-1:0] FM_H  = CW'(OSR_FM / 2);
  localparam logic [CW-1:0] FM_Q3 = CW'(3 * OSR_FM / 4);
  localparam logic [CW-1:0] NZ_H  = CW'(OSR_NRZ / 2);
  localparam logic [CW-1:0] FM_L  = CW'(OSR_FM - 1);
  localparam logic [CW-1:0] NZ_L  = CW'(OSR_NRZ - 1);

  wire fm   = (mode == 2'b10);
  wire nrzi = (mode == 2'b01);

  // transmit encoder
  logic [CW-1:0] hc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_line <= 1'b1;
      hc      <= '0;
    end else if (tx_stb) begin
      if (fm) begin
        tx_line <= ~tx_line;
        hc      <= tx_bit ? '0 : FM_H;
      end else begin
        hc <= '0;
        if (nrzi) begin
          if (!tx_bit) tx_line <= ~tx_line;
        end else begin
          tx_line <= tx_bit;
        end
      end
    end else if (hc != '0) begin
      hc <= hc - 1'b1;
      if (hc == CW'(1) && fm) tx_line <= ~tx_line;
    end
  end

  // R1
  nrz_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && tx_stb) |=> tx_line == $past(tx_bit));
  // R1
  nrz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !tx_stb) |=> $stable(tx_line));
  // R2
  nrzi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && tx_stb && !tx_bit) |=> tx_line != $past(tx_line));
  // R2
  nrzi_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && tx_stb && tx_bit) |=> $stable(tx_line));
  // R3
  fm_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && tx_stb) |=> tx_line != $past(tx_line));

  // receive synchronizers
  logic s1, rxs, rxd, e1, e2, e3;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s1, rxs, rxd} <= 3'b111;
      {e1, e2, e3}   <= 3'b000;
    end else begin
      {s1, rxs, rxd} <= {rx_line, s1, rxs};
      {e1, e2, e3}   <= {ext_bclk, e1, e2};
    end
  end

  // phase counter
  logic [CW-1:0] cnt;
  logic          hunt, bnd;
  logic [1:0]    miss;
  wire [CW-1:0] last    = fm ? FM_L : NZ_L;
  wire          edge_d  = !ext_sel && (rxs ^ rxd);
  wire          late_w  = (cnt != '0) && (fm ? (cnt < FM_Q) : (cnt < NZ_H));
  wire          early_w = fm ? (cnt >= FM_Q3) : (cnt >= NZ_H);
  wire          check   = fm && !ext_sel && (cnt == FM_H);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (edge_d && hunt)    cnt <= CW'(1);
    else if (edge_d && late_w)  cnt <= cnt;
    else if (edge_d && early_w) cnt <= (cnt >= last) ? CW'(1) :
                                       (cnt == last - 1'b1) ? '0 : cnt + 2'd2;
    else                        cnt <= (cnt >= last) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hunt <= 1'b1;
      bnd  <= 1'b0;
      miss <= 2'd0;
    end else begin
      if (edge_d) hunt <= 1'b0;
      else if (check && !bnd && miss == 2'd1) hunt <= 1'b1;
      if (!fm || ext_sel) begin
        miss <= 2'd0;
        bnd  <= 1'b0;
      end else if (edge_d && (hunt || late_w || early_w || cnt == '0)) begin
        bnd <= 1'b1;
        if (hunt) miss <= 2'd0;
      end else if (check) begin
        bnd  <= 1'b0;
        miss <= bnd ? 2'd0 : ((miss == 2'd2) ? 2'd2 : miss + 2'd1);
      end
    end
  end
  assign clk_miss = (miss == 2'd2);

  // R7
  miss_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b10 || ext_sel) |=> !clk_miss);

  // decision
  logic q, ps;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_vld <= 1'b0;
      rx_bit <= 1'b0;
      q      <= 1'b1;
      ps     <= 1'b1;
    end else begin
      rx_vld <= 1'b0;
      if (ext_sel) begin
        if (e2 && !e3) begin
          rx_vld <= 1'b1;
          rx_bit <= nrzi ? (rxs == ps) : rxs;
          ps     <= rxs;
        end
      end else if (fm) begin
        if (cnt == FM_Q) q <= rxs;
        if (cnt == FM_Q3) begin
          rx_vld <= 1'b1;
          rx_bit <= (rxs == q);
        end
      end else if (cnt == NZ_H) begin
        rx_vld <= 1'b1;
        rx_bit <= nrzi ? (rxs == ps) : rxs;
        ps     <= rxs;
      end
    end
  end

  // R11
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |=> !rx_vld);
endmodule

// File: tb/line_codec_test.sv
module line_codec_test;
  localparam int FO = 8;
  localparam int NO = 16;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 2'b00;
  logic ext_sel = 0, ext_bclk = 0, tx_bit = 0, tx_stb = 0;
  logic loop = 0, rx_drv = 1;
  logic tx_line, rx_bit, rx_vld, clk_miss;
  wire  rx_line = loop ? tx_line : rx_drv;

  line_codec #(.OSR_FM(FO), .OSR_NRZ(NO)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ext_sel(ext_sel), .ext_bclk(ext_bclk),
    .tx_bit(tx_bit), .tx_stb(tx_stb), .tx_line(tx_line), .rx_line(rx_line),
    .rx_bit(rx_bit), .rx_vld(rx_vld), .clk_miss(clk_miss));

  always #10 clk = ~clk;

  int nt = 0, nf = 0, rxn = 0, dbl = 0;
  bit rxbuf [0:8191];
  bit pv = 0, exp_l = 1, done = 0;

  always @(negedge clk) begin
    if (rx_vld && rxn < 8192) begin
      rxbuf[rxn] <= rx_bit;
      rxn <= rxn + 1;
    end
    if (rx_vld && pv) dbl <= dbl + 1;
    pv <= rx_vld;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nt++;
    if (!ok) begin
      nf++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input logic b);
    @(negedge clk);
    rst_n = 0; mode = m; ext_sel = b; tx_stb = 0; rx_drv = 1; ext_bclk = 0;
    exp_l = 1;
    repeat (4) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send_bit(input bit b);
    string tg;
    int osr;
    tg  = (mode == 2'b01) ? "R2" : (mode == 2'b10) ? "R3" : "R1";
    osr = (mode == 2'b10) ? FO : NO;
    @(negedge clk);
    tx_bit = b; tx_stb = 1;
    if (mode == 2'b01) begin
      if (!b) exp_l = ~exp_l;
    end else if (mode == 2'b10) exp_l = ~exp_l;
    else exp_l = b;
    for (int k = 1; k < osr; k++) begin
      @(negedge clk);
      if (k == 1) begin
        tx_stb = 0;
        chk(tx_line == exp_l, tg, tx_line, exp_l);
      end
      if (mode == 2'b10 && k == FO / 2 + 2) begin
        if (!b) exp_l = ~exp_l;
        chk(tx_line == exp_l, "R3 mid", tx_line, exp_l);
      end
    end
  endtask

  function automatic logic [31:0] pay(input int s);
    return s * 32'h9E3779B1 + 32'h7F4A7C15;
  endfunction

  function automatic bit found(input logic [31:0] p, input int from);
    bit ok;
    for (int o = from; o + 24 <= rxn; o++) begin
      ok = 1;
      for (int i = 0; i < 24; i++) if (rxbuf[o + i] != p[i]) ok = 0;
      if (ok) return 1;
    end
    return 0;
  endfunction

  task automatic run_frame(input logic [31:0] p);
    send_bit(0); send_bit(1); send_bit(0); send_bit(1);
    for (int i = 0; i < 24; i++) send_bit(p[i]);
    send_bit(1); send_bit(0); send_bit(1);
    repeat (3 * NO) @(negedge clk);
  endtask

  task automatic byp_bit(input bit lvl);
    @(negedge clk); rx_drv = lvl; ext_bclk = 0;
    @(negedge clk);
    @(negedge clk); ext_bclk = 1;
    @(negedge clk);
  endtask

  task automatic drift(input int per);
    int r0, n;
    bit alt;
    do_reset(2'b00, 0);
    loop = 0;
    r0 = rxn;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk); rx_drv = c[0];
      repeat (per - 1) @(negedge clk);
    end
    n = rxn - r0;
    chk(n >= 58 && n <= 62, "R10 count", n, 60);
    alt = 1;
    for (int i = r0 + 3; i < r0 + 50; i++) if (rxbuf[i] == rxbuf[i + 1]) alt = 0;
    chk(alt, "R10 alternation", alt, 1);
  endtask

  initial begin
    int r0;
    logic [31:0] p;
    bit lvl;
    string tg;
    do_reset(2'b00, 0);
    @(negedge clk);
    chk(tx_line == 1, "R8 tx_line", tx_line, 1);
    chk(rx_vld == 0, "R8 rx_vld", rx_vld, 0);
    chk(clk_miss == 0, "R8 clk_miss", clk_miss, 0);

    // loopback sweep over encodings and payloads
    for (int m = 0; m < 3; m++) begin
      for (int s = 1; s <= 6; s++) begin
        do_reset(m[1:0], 0);
        loop = 1;
        p = pay(s + 10 * m);
        r0 = rxn;
        run_frame(p);
        tg = (m == 1) ? "R5" : (m == 2) ? "R6" : "R4";
        chk(found(p, r0), tg, 0, 1);
      end
    end

    // R7: FM clock-missing flag
    do_reset(2'b10, 0);
    loop = 1;
    for (int i = 0; i < 10; i++) send_bit(i[0]);
    chk(clk_miss == 0, "R7 while edges", clk_miss, 0);
    repeat (8 * FO) @(negedge clk);
    chk(clk_miss == 1, "R7 after idle", clk_miss, 1);
    r0 = rxn;
    p = pay(77);
    send_bit(0); send_bit(1); send_bit(0); send_bit(1);
    chk(clk_miss == 0, "R7 cleared", clk_miss, 0);
    for (int i = 0; i < 24; i++) send_bit(p[i]);
    send_bit(1); send_bit(0);
    repeat (2 * FO) @(negedge clk);
    chk(found(p, r0), "R7 relock", 0, 1);
    do_reset(2'b00, 0);
    repeat (8 * NO) @(negedge clk);
    chk(clk_miss == 0, "R7 NRZ idle", clk_miss, 0);

    // R9: external bit clock
    for (int m = 0; m < 2; m++) begin
      for (int s = 1; s <= 4; s++) begin
        do_reset(m[1:0], 1);
        loop = 0;
        p = pay(100 + s);
        lvl = 1;
        r0 = rxn;
        for (int i = -4; i < 28; i++) begin
          bit b;
          b = (i < 0) ? i[0] : (i < 24) ? p[i] : 1'b1;
          if (m == 1) begin
            if (!b) lvl = ~lvl;
          end else lvl = b;
          byp_bit(lvl);
        end
        repeat (8) @(negedge clk);
        chk(found(p, r0), m == 1 ? "R9 NRZI" : "R9 NRZ", 0, 1);
      end
    end

    // R10: off-rate tracking
    drift(NO + 1);
    drift(NO - 1);

    chk(dbl == 0, "R11 double strobe", dbl, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nt++; nf++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nt, nf);
      $finish;
    end
  end
endmodule